// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits in the command path of a synchronous DRAM controller or model. It keeps a mode register that is written by a mode-set command. For every read or write command it produces the column address sequence of one burst. It captures the starting column and bank of the command. From the next cycle on it issues one column per clock.

A burst ends in one of three ways: the programmed length runs out, a stop command arrives, or a new read or write replaces it on any cycle. The generator supports two orders. Sequential order wraps inside an aligned block of the burst length. Interleaved order combines the start offset with the beat number by XOR. A full-page length also exists; it runs over all columns and wraps until it is stopped.

The mode word carries four fields: burst length, burst order, read latency and write mode. The block decodes these fields and presents the read latency and a flag for reserved settings.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `burst_active` and `last_beat` are 0 and `col_addr` is 0. The mode register holds 10'h020, which selects length 1, sequential order, read latency 2 and burst write, so `read_lat`=2 and `mode_rsvd`=0.
- R2: Command codes on `cmd` are 3'b001 mode-set, 3'b010 read, 3'b011 write and 3'b100 stop; every other code is a no-op. A mode-set loads `mode_in[9:0]`. From the cycle after the mode-set, `read_lat` is 2 for latency field `mode[6:4]`=010 and 3 for 011. Every other latency code gives `read_lat`=0 and `mode_rsvd`=1.
- R3: Length field `mode[2:0]` codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. A read or write sampled at a clock edge makes beat 0 visible right after that edge. Beat k appears k cycles later. `last_beat` is high only on the final beat, and `burst_active` falls the cycle after it.
- R4: With order bit `mode[3]`=0 (sequential), beat k carries the address `(start & ~(BL-1)) | ((start+k) & (BL-1))`. The count wraps inside the aligned block and the upper bits stay unchanged.
- R5: With `mode[3]`=1 (interleaved), beat k carries the address `start ^ k`.
- R6: Length code 111 with sequential order selects a full page. The column count runs `(start+k) mod 512` and keeps going past 512 beats. `last_beat` never rises, and only a stop or a new read or write ends the burst.
- R7: Length codes 100, 101 and 110, and code 111 with interleaved order, are reserved. They give bursts of exactly 1 beat and set `mode_rsvd`=1.
- R8: Write-mode bit `mode[9]`=1 makes every write a single beat with `burst_write`=1. Reads keep the programmed length with `burst_write`=0.
- R9: A stop sampled during a burst drops `burst_active` at once on the next cycle. A stop while idle has no effect: the outputs stay idle and the next read runs normally.
- R10: A read or write sampled while a burst is active abandons the old burst. The new start column and bank show up on the next cycle as beat 0.
- R11: A mode-set during a burst leaves the running burst on its captured length and order. The new settings apply from the next read or write.
- R12: `bank_addr` holds the bank of the current burst for its whole length. `burst_write` tells whether that burst is a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code: 001 mode-set, 010 read, 011 write, 100 stop, others no-op |
| mode_in | input | 10 | Mode word loaded by mode-set |
| start_col | input | COL_W | Starting column of a read or write |
| start_bank | input | BANK_W | Bank of a read or write |
| col_addr | output | COL_W | Column of the current beat, 0 when idle |
| bank_addr | output | BANK_W | Bank of the current burst |
| burst_active | output | 1 | A burst beat is being issued |
| last_beat | output | 1 | Current beat is the final one of a finite burst |
| burst_write | output | 1 | Current burst is a write |
| read_lat | output | 2 | Decoded read latency, 0 if reserved |
| mode_rsvd | output | 1 | Mode register holds a reserved length or latency |

## Verification
Each command is sampled at one rising edge. Its effect is due in the cycle that follows: beat 0 of a read or write, the idle state after a stop, and the new decoded latency and reserved flag after a mode-set. Beat k then follows k cycles later. The bench applies inputs on falling edges and checks outputs on the next falling edge, half a cycle after the edge that updated them. A burst of length BL is therefore checked over BL falling edges, and the idle state is checked at the edge after that.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd,
  input  logic [9:0]        mode_in,
  input  logic [COL_W-1:0]  start_col,
  input  logic [BANK_W-1:0] start_bank,
  output logic [COL_W-1:0]  col_addr,
  output logic [BANK_W-1:0] bank_addr,
  output logic              burst_active,
  output logic              last_beat,
  output logic              burst_write,
  output logic [1:0]        read_lat,
  output logic              mode_rsvd
);
  localparam int LG_W = $clog2(COL_W + 1);
  localparam logic [2:0] C_MRS = 3'b001, C_RD = 3'b010, C_WR = 3'b011, C_STOP = 3'b100;
  localparam logic [9:0] MODE_RST = 10'h020;

  logic [9:0]        mode_q;
  logic [COL_W-1:0]  base_q, beat_q;
  logic [LG_W-1:0]   lg_q;
  logic              il_q, full_q;

  wire [2:0] len_code = mode_q[2:0];
  wire       il_mode  = mode_q[3];
  wire [2:0] lat_code = mode_q[6:4];
  wire       single_w = mode_q[9];

  wire full_mode = (len_code == 3'b111) && !il_mode;
  wire len_rsvd  = len_code[2] && !full_mode;
  wire lat_rsvd  = (lat_code != 3'b010) && (lat_code != 3'b011);

  wire [LG_W-1:0] lg_mode = full_mode   ? LG_W'(COL_W) :
                            len_code[2] ? '0 : LG_W'(len_code[1:0]);

  wire is_rdwr  = (cmd == C_RD) || (cmd == C_WR);
  wire is_wr    = (cmd == C_WR);
  wire shrink_w = is_wr && single_w;

  wire [COL_W-1:0] mask    = ~({COL_W{1'b1}} << lg_q);
  wire [COL_W-1:0] seq_col = (base_q & ~mask) | ((base_q + beat_q) & mask);
  wire [COL_W-1:0] il_col  = base_q ^ beat_q;

  assign read_lat  = lat_rsvd ? 2'd0 : lat_code[1:0];
  assign mode_rsvd = len_rsvd || lat_rsvd;
  assign last_beat = burst_active && !full_q && (beat_q == mask);
  assign col_addr  = !burst_active ? '0 : (il_q ? il_col : seq_col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RST;
    else if (cmd == C_MRS) mode_q <= mode_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_active <= 1'b0;
      burst_write  <= 1'b0;
      base_q       <= '0;
      beat_q       <= '0;
      bank_addr    <= '0;
      lg_q         <= '0;
      il_q         <= 1'b0;
      full_q       <= 1'b0;
    end else if (is_rdwr) begin
      burst_active <= 1'b1;
      burst_write  <= is_wr;
      base_q       <= start_col;
      beat_q       <= '0;
      bank_addr    <= start_bank;
      lg_q         <= shrink_w ? '0 : lg_mode;
      il_q         <= il_mode && !shrink_w;
      full_q       <= full_mode && !shrink_w;
    end else if (cmd == C_STOP) begin
      burst_active <= 1'b0;
    end else if (burst_active) begin
      if (last_beat) burst_active <= 1'b0;
      else           beat_q <= beat_q + 1'b1;
    end
  end
endmodule

module burst_col_gen_chk #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [COL_W-1:0]  start_col,
  input logic [BANK_W-1:0] start_bank,
  input logic [COL_W-1:0]  col_addr,
  input logic [BANK_W-1:0] bank_addr,
  input logic              burst_active,
  input logic              last_beat
);
  wire rdwr = (cmd == 3'b010) || (cmd == 3'b011);
  wire stop = (cmd == 3'b100);

  p_last_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> burst_active);

  p_end_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !rdwr) |=> !burst_active);

  p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !burst_active);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdwr |=> (burst_active && col_addr == $past(start_col) && bank_addr == $past(start_bank)));

  p_bank_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !last_beat && !rdwr && !stop) |=> (burst_active && $stable(bank_addr)));

  p_idle_col_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active |-> (col_addr == '0 && !last_beat));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .start_col(start_col), .start_bank(start_bank),
  .col_addr(col_addr), .bank_addr(bank_addr), .burst_active(burst_active),
  .last_beat(last_beat)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  localparam logic [2:0] NOP = 3'b000, MRS = 3'b001, RD = 3'b010, WR = 3'b011, STP = 3'b100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = NOP;
  logic [9:0] mode_in = '0;
  logic [8:0] start_col = '0;
  logic [1:0] start_bank = '0;
  logic [8:0] col_addr;
  logic [1:0] bank_addr, read_lat;
  logic       burst_active, last_beat, burst_write, mode_rsvd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .mode_in(mode_in),
    .start_col(start_col), .start_bank(start_bank),
    .col_addr(col_addr), .bank_addr(bank_addr), .burst_active(burst_active),
    .last_beat(last_beat), .burst_write(burst_write),
    .read_lat(read_lat), .mode_rsvd(mode_rsvd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int k, input int bl, input bit il);
    if (il) return (s ^ k) & 511;
    return ((s & ~(bl - 1)) | ((s + k) & (bl - 1))) & 511;
  endfunction

  function automatic logic [9:0] mk(input int code, input bit il, input int lat, input bit wm);
    return {wm, 2'b00, 3'(lat), il, 3'(code)};
  endfunction

  task automatic set_mode(input logic [9:0] m);
    @(negedge clk) begin cmd = MRS; mode_in = m; end
    @(negedge clk) cmd = NOP;
  endtask

  task automatic issue(input logic [2:0] c, input int s, input int b);
    @(negedge clk) begin cmd = c; start_col = 9'(s); start_bank = 2'(b); end
    @(negedge clk) cmd = NOP;
  endtask

  task automatic beats(input int s, input int b, input int bl, input bit il,
                       input int from, input int upto, input bit wexp, input string tag);
    for (int k = from; k < upto; k++) begin
      chk(burst_active === 1'b1, {tag, " active"}, int'(burst_active), 1);
      chk(col_addr === 9'(exp_col(s, k, bl, il)), {tag, " col"}, int'(col_addr), exp_col(s, k, bl, il));
      chk(last_beat === (k == bl - 1), {tag, " last"}, int'(last_beat), int'(k == bl - 1));
      chk(bank_addr === 2'(b), "R12 bank", int'(bank_addr), b);
      chk(burst_write === wexp, "R12 write flag", int'(burst_write), int'(wexp));
      if (k < upto - 1) @(negedge clk);
    end
  endtask

  task automatic full_burst(input logic [2:0] c, input int s, input int b, input int bl,
                            input bit il, input bit wexp, input string tag);
    issue(c, s, b);
    beats(s, b, bl, il, 0, bl, wexp, tag);
    @(negedge clk);
    chk(burst_active === 1'b0, {tag, " ends"}, int'(burst_active), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(burst_active === 1'b0, "R1 active", int'(burst_active), 0);
    chk(last_beat === 1'b0, "R1 last", int'(last_beat), 0);
    chk(col_addr === 9'd0, "R1 col", int'(col_addr), 0);
    chk(read_lat === 2'd2, "R1 latency", int'(read_lat), 2);
    chk(mode_rsvd === 1'b0, "R1 rsvd", int'(mode_rsvd), 0);
    full_burst(RD, 77, 1, 1, 0, 0, "R1 default burst");

    for (int lc = 0; lc < 8; lc++) begin
      set_mode(mk(1, 0, lc, 0));
      chk(read_lat === ((lc == 2) ? 2'd2 : (lc == 3) ? 2'd3 : 2'd0), "R2 latency",
          int'(read_lat), (lc == 2) ? 2 : (lc == 3) ? 3 : 0);
      chk(mode_rsvd === !(lc == 2 || lc == 3), "R2 rsvd", int'(mode_rsvd), int'(!(lc == 2 || lc == 3)));
    end

    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++) begin
        set_mode(mk(code, il[0], 3, 0));
        chk(mode_rsvd === 1'b0, "R3 rsvd clear", int'(mode_rsvd), 0);
        for (int s = 0; s < 18; s++) begin
          int sc;
          sc = (s == 16) ? 509 : (s == 17) ? 250 : s;
          full_burst(RD, sc, sc % 4, 1 << code, il[0], 0, il ? "R5 interleave" : "R4 sequential");
        end
        full_burst(WR, 13, 3, 1 << code, il[0], 1, "R3 write burst");
      end

    for (int code = 4; code < 8; code++) begin
      set_mode(mk(code, code == 7, 2, 0));
      chk(mode_rsvd === 1'b1, "R7 rsvd flag", int'(mode_rsvd), 1);
      full_burst(RD, 37, 2, 1, 0, 0, "R7 reserved len");
    end

    set_mode(mk(7, 0, 2, 0));
    chk(mode_rsvd === 1'b0, "R6 rsvd", int'(mode_rsvd), 0);
    issue(RD, 500, 2);
    for (int k = 0; k < 530; k++) begin
      chk(burst_active === 1'b1, "R6 active", int'(burst_active), 1);
      chk(col_addr === 9'((500 + k) % 512), "R6 col", int'(col_addr), (500 + k) % 512);
      chk(last_beat === 1'b0, "R6 no last", int'(last_beat), 0);
      if (k < 529) @(negedge clk);
    end
    cmd = STP;
    @(negedge clk) cmd = NOP;
    chk(burst_active === 1'b0, "R6 stopped", int'(burst_active), 0);

    set_mode(mk(3, 0, 2, 1));
    full_burst(WR, 21, 1, 1, 0, 1, "R8 single write");
    full_burst(RD, 21, 1, 8, 0, 0, "R8 read keeps length");
    set_mode(mk(3, 1, 2, 1));
    full_burst(WR, 6, 0, 1, 0, 1, "R8 single write il");

    set_mode(mk(3, 0, 2, 0));
    issue(RD, 10, 1);
    beats(10, 1, 8, 0, 0, 3, 0, "R9 before stop");
    cmd = STP;
    @(negedge clk) cmd = NOP;
    chk(burst_active === 1'b0, "R9 stop", int'(burst_active), 0);
    chk(col_addr === 9'd0, "R9 stop col", int'(col_addr), 0);
    issue(STP, 0, 0);
    chk(burst_active === 1'b0, "R9 idle stop", int'(burst_active), 0);
    chk(col_addr === 9'd0, "R9 idle col", int'(col_addr), 0);
    full_burst(RD, 42, 0, 8, 0, 0, "R9 after idle stop");

    issue(RD, 3, 0);
    beats(3, 0, 8, 0, 0, 2, 0, "R10 first");
    start_col = 9'd20; start_bank = 2'd2; cmd = WR;
    @(negedge clk) cmd = NOP;
    beats(20, 2, 8, 0, 0, 8, 1, "R10 replaced");
    @(negedge clk);
    chk(burst_active === 1'b0, "R10 ends", int'(burst_active), 0);

    set_mode(mk(2, 0, 2, 0));
    issue(RD, 7, 3);
    beats(7, 3, 4, 0, 0, 2, 0, "R11 before");
    mode_in = mk(3, 1, 3, 0); cmd = MRS;
    @(negedge clk) cmd = NOP;
    beats(7, 3, 4, 0, 2, 4, 0, "R11 kept");
    @(negedge clk);
    chk(burst_active === 1'b0, "R11 ends", int'(burst_active), 0);
    chk(read_lat === 2'd3, "R11 new latency", int'(read_lat), 3);
    full_burst(RD, 7, 3, 8, 1, 0, "R11 new mode");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule